// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block is the digital sequencing core of a half-bridge gate driver for a synchronous buck stage. A digital PWM command selects which switch should conduct. The high-side request is PWM high and the low-side request is PWM low. The block never enables the two switches together. Between them it inserts a dead time whose length is set by sensed voltages, not by a fixed delay.

When the high side is switched off, the low side waits for a comparator flag reporting that the switch node has fallen below roughly 2 V. When the low side is switched off, the high side waits for a second flag reporting that the low-side gate has collapsed below roughly 1 V. With negative inductor current the switch node may never fall. A cycle-counted watchdog therefore turns the low side on anyway, so that the current can recirculate.

A supervisory block can override the sequencer in two ways. A force-off input blanks both enables at once. A force-low-side input holds the low side on and the high side off. Both comparator flags pass through a flop synchronizer before the sequencer uses them. PWM and the two force inputs are taken to be synchronous to the clock.

Top module: `dtg_top`

## Requirements
- R1: `hs_en` and `ls_en` are never 1 in the same cycle.
- R2: After the high side turns off on PWM low, `ls_en` rises on the clock edge that follows the first cycle in which the synchronized switch-node flag (`sw_below`=1 means the node is low) is seen as 1.
- R3: After the low side turns off on PWM high, `hs_en` rises only on the edge that follows a cycle in which the synchronized gate flag (`lg_below`=1 means the gate is low) is 1. While that flag stays 0, `hs_en` stays 0.
- R4: If the synchronized switch-node flag stays 0 after high-side turn-off, `ls_en` rises exactly `WD_CYCLES` clock edges after `hs_en` fell (default 16).
- R5: PWM high requests the high side and PWM low requests the low side. From idle, PWM low enables the low side on the next edge, and PWM high passes through the gate-flag wait.
- R6: `force_off`=1 drives both enables to 0 in the same cycle, combinationally, and overrides every other input. On release, sequencing restarts from idle.
- R7: `force_ls`=1 (with `force_off`=0) drives `ls_en` to 1 in the same cycle and holds `hs_en` at 0 whatever PWM does. On release with PWM high, the gate-flag wait applies.
- R8: A change on a comparator flag reaches the sequencer after `SYNC_STAGES` edges (default 2). A flag rise therefore takes effect on the third edge after the input changes.
- R9: While `rst_n`=0, both enables are 0 and the sequencer returns to idle.
- R10: If PWM returns high while the switch-node wait is pending, that wait is abandoned and the gate-flag wait of R3 applies. The low side is not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm | input | 1 | PWM command: 1 high side, 0 low side |
| sw_below | input | 1 | Comparator: switch node below low threshold |
| lg_below | input | 1 | Comparator: low-side gate below threshold |
| force_off | input | 1 | Supervisory: both switches off |
| force_ls | input | 1 | Supervisory: low side on, high side off |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The bench drives a small plant whose comparator flags follow the enables after a delay. It breaks that plant in several ways: the switch node never falls, the gate flag is held high, and PWM flips back while a wait is still open. In those cases a design that watched the wrong flag, or dropped the wait, would overlap the two enables or turn the high side on early. The watchdog edge count is measured exactly, so an off-by-one limit shows up as a late or early low-side turn-on. Force inputs are applied mid-phase and sampled before the next edge, so a registered override would show the old enable for one cycle. A synchronizer with the wrong depth shifts the measured three-edge latency of a gate-flag rise.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_HS     = 3'd1,
      ST_GAP_LS = 3'd2,
      ST_LS     = 3'd3,
      ST_GAP_HS = 3'd4
   } dtg_state_e;
endpackage

// File: rtl/dtg_sync.sv
`timescale 1ns/1ps
module dtg_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial assert (STAGES >= 2) else $fatal(1, "dtg_sync: STAGES must be at least 2");
   initial assert (WIDTH >= 1) else $fatal(1, "dtg_sync: WIDTH must be positive");

   logic [WIDTH-1:0] chain [STAGES];

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= '0;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dtg_wdog.sv
`timescale 1ns/1ps
module dtg_wdog #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   initial assert (LIMIT >= 2) else $fatal(1, "dtg_wdog: LIMIT must be at least 2");

   localparam int CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt;

   assign expired = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)               cnt <= '0;
      else if (run && !expired) cnt <= cnt + 1'b1;
      else                      cnt <= '0;

   // R4: the count never passes the limit
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST);
   // R4: an idle timer restarts from zero
   p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n) !run |=> cnt == '0);
endmodule

// File: rtl/dtg_fsm.sv
`timescale 1ns/1ps
module dtg_fsm
   import dtg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwm,
   input  logic       force_off,
   input  logic       force_ls,
   input  logic       sw_s,
   input  logic       lg_s,
   input  logic       wd_exp,
   output dtg_state_e state,
   output logic       wd_run
);
   dtg_state_e nxt;

   always_comb begin
      nxt = state;
      if (force_off)      nxt = ST_IDLE;
      else if (force_ls)  nxt = ST_LS;
      else begin
         unique case (state)
            ST_IDLE:   nxt = pwm ? ST_GAP_HS : ST_LS;
            ST_HS:     if (!pwm) nxt = ST_GAP_LS;
            ST_GAP_LS: if (pwm) nxt = ST_GAP_HS;
                       else if (sw_s || wd_exp) nxt = ST_LS;
            ST_LS:     if (pwm) nxt = ST_GAP_HS;
            ST_GAP_HS: if (!pwm) nxt = ST_LS;
                       else if (lg_s) nxt = ST_HS;
            default:   nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;

   assign wd_run = (state == ST_GAP_LS);

   // R2: node flag seen in the gap moves to low-side conduction
   p_ls_on_node_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_GAP_LS && sw_s && !pwm && !force_off && !force_ls) |=> state == ST_LS);
   // R3: high side is entered only after the gate flag was seen
   p_hs_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == ST_HS) |-> $past(lg_s) && $past(state == ST_GAP_HS));
   // R4: watchdog expiry turns the low side on
   p_wd_fallback_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_exp && !pwm && !force_off && !force_ls) |=> state == ST_LS);
   // R6: force-off returns the sequencer to idle
   p_force_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      force_off |=> state == ST_IDLE);
   // R7: force-low-side lands in low-side conduction
   p_force_ls_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (force_ls && !force_off) |=> state == ST_LS);
   // R10: PWM high during the node wait leaves for the gate wait
   p_abandon_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_GAP_LS && pwm && !force_off && !force_ls) |=> state == ST_GAP_HS);
endmodule

// File: rtl/dtg_top.sv
`timescale 1ns/1ps
module dtg_top
   import dtg_pkg::*;
#(
   parameter int WD_CYCLES   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm,
   input  logic sw_below,
   input  logic lg_below,
   input  logic force_off,
   input  logic force_ls,
   output logic hs_en,
   output logic ls_en
);
   localparam int N_FLAGS = 2;

   logic [N_FLAGS-1:0] flags_s;
   logic               sw_s, lg_s, wd_exp, wd_run;
   dtg_state_e         state;

   dtg_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_FLAGS)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({lg_below, sw_below}), .q(flags_s));

   assign sw_s = flags_s[0];
   assign lg_s = flags_s[1];

   dtg_wdog #(.LIMIT(WD_CYCLES)) u_wdog (
      .clk(clk), .rst_n(rst_n), .run(wd_run), .expired(wd_exp));

   dtg_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .pwm(pwm), .force_off(force_off), .force_ls(force_ls),
      .sw_s(sw_s), .lg_s(lg_s), .wd_exp(wd_exp), .state(state), .wd_run(wd_run));

   assign hs_en = rst_n && !force_off && !force_ls && (state == ST_HS);
   assign ls_en = rst_n && !force_off && (force_ls || state == ST_LS);

   // R1: never both enables
   p_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n) !(hs_en && ls_en));
   // R8: a synchronized flag rise comes from an input two edges back
   generate
      if (SYNC_STAGES == 2) begin : g_sync_chk
         p_sync_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lg_s) |-> $past(lg_below, 2));
      end
   endgenerate
   // R9: reset leaves both enables low
   always_comb if (!rst_n) p_reset_off_r9: assert (!hs_en && !ls_en);
endmodule

// File: tb/sim_dtg_top.sv
`timescale 1ns/1ps
module sim_dtg_top;
   localparam int WD = 16;
   localparam int IDLE = 0, HS = 1, GLS = 2, LS = 3, GHS = 4;

   logic clk = 0, rst_n = 0, pwm = 0, sw_below = 0, lg_below = 0;
   logic force_off = 0, force_ls = 0;
   logic hs_en, ls_en;

   int tests = 0, fails = 0;
   string cur_req = "R9";
   bit plant_on = 0, node_falls = 1;
   logic [2:0] hs_d = '0, ls_d = '0;

   // reference model state
   int m_st = IDLE, m_wd = 0;
   int swq[$] = '{0, 0};
   int lgq[$] = '{0, 0};

   always #2 clk = ~clk;

   dtg_top #(.WD_CYCLES(WD), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .pwm(pwm), .sw_below(sw_below), .lg_below(lg_below),
      .force_off(force_off), .force_ls(force_ls), .hs_en(hs_en), .ls_en(ls_en));

   task automatic check(string req, logic act_h, logic act_l, logic exp_h, logic exp_l);
      tests++;
      if (act_h !== exp_h || act_l !== exp_l) begin
         fails++;
         $display("FAIL %s t=%0t hs/ls actual %b%b expected %b%b", req, $time,
                  act_h, act_l, exp_h, exp_l);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   // model: one step per rising edge, compared 1 ns later
   always @(posedge clk) begin
      int sw_s, lg_s, nx;
      bit exp_wd;
      if (!rst_n) begin
         m_st = IDLE; m_wd = 0; swq = '{0, 0}; lgq = '{0, 0};
      end else begin
         sw_s = swq[0]; lg_s = lgq[0];
         exp_wd = (m_st == GLS) && (m_wd + 1 >= WD);
         nx = m_st;
         if (force_off) nx = IDLE;
         else if (force_ls) nx = LS;
         else if (m_st == IDLE) nx = pwm ? GHS : LS;
         else if (m_st == HS && !pwm) nx = GLS;
         else if (m_st == GLS) begin
            if (pwm) nx = GHS;
            else if (sw_s == 1 || exp_wd) nx = LS;
         end else if (m_st == LS && pwm) nx = GHS;
         else if (m_st == GHS) begin
            if (!pwm) nx = LS;
            else if (lg_s == 1) nx = HS;
         end
         m_wd = (m_st == GLS && nx == GLS) ? m_wd + 1 : 0;
         m_st = nx;
         void'(swq.pop_front()); swq.push_back(int'(sw_below));
         void'(lgq.pop_front()); lgq.push_back(int'(lg_below));
      end
      #1;
      check({"model ", cur_req}, hs_en, ls_en,
            rst_n && !force_off && !force_ls && m_st == HS,
            rst_n && !force_off && (force_ls || m_st == LS));
   end

   // plant: comparator flags follow the enables after three cycles
   always @(negedge clk) if (plant_on) begin
      hs_d <= {hs_d[1:0], hs_en};
      ls_d <= {ls_d[1:0], ls_en};
      sw_below <= node_falls && !hs_d[2];
      lg_below <= !ls_d[2];
   end

   initial begin
      repeat (60000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish");
      summary();
   end

   task automatic cyc(int n); repeat (n) @(negedge clk); endtask

   initial begin
      int n;
      // R9 reset state
      cyc(3);
      #0.5 check("R9 reset", hs_en, ls_en, 0, 0);
      rst_n = 1;

      // R5 / R2 / R3: normal switching with varied duty
      cur_req = "R5 R2 R3"; plant_on = 1; node_falls = 1;
      for (int k = 0; k < 6; k++) begin
         pwm = 1; cyc(8 + 3 * k);
         pwm = 0; cyc(10 + 2 * k);
      end

      // R4: node never falls, measure edges from hs fall to ls rise
      cur_req = "R4"; node_falls = 0;
      pwm = 1; cyc(12);
      pwm = 0;
      @(negedge hs_en);
      n = 0;
      while (!ls_en && n < 100) begin @(posedge clk); n++; #0.5; end
      tests++;
      if (n != WD) begin
         fails++;
         $display("FAIL R4 watchdog edges actual %0d expected %0d", n, WD);
      end
      cyc(6);

      // R10: pwm returns high while node wait is pending
      cur_req = "R10";
      pwm = 1; cyc(12);
      pwm = 0; cyc(5);
      pwm = 1; cyc(12);
      #0.5 check("R10 back to high side", hs_en, ls_en, 1, 0);
      pwm = 0; cyc(WD + 6);
      node_falls = 1;

      // R6: force-off is immediate and overrides
      cur_req = "R6";
      pwm = 1; cyc(12);
      force_off = 1;
      #0.5 check("R6 immediate", hs_en, ls_en, 0, 0);
      cyc(4);
      force_off = 0; cyc(12);
      force_off = 1; force_ls = 1;
      #0.5 check("R6 over force_ls", hs_en, ls_en, 0, 0);
      cyc(3);
      force_off = 0; force_ls = 0; cyc(12);

      // R7: force low side with pwm high
      cur_req = "R7";
      force_ls = 1;
      #0.5 check("R7 immediate", hs_en, ls_en, 0, 1);
      cyc(8);
      force_ls = 0; cyc(14);

      // R8 / R3: manual flags, gate flag held high blocks high side
      cur_req = "R8 R3"; plant_on = 0;
      sw_below = 0; lg_below = 0;
      pwm = 0; cyc(6);
      pwm = 1; cyc(10);
      #0.5 check("R3 blocked by gate flag", hs_en, ls_en, 0, 0);
      lg_below = 1;
      n = 0;
      while (!hs_en && n < 20) begin @(posedge clk); n++; #0.5; end
      tests++;
      if (n != 3) begin
         fails++;
         $display("FAIL R8 gate flag latency actual %0d expected %0d", n, 3);
      end
      cyc(3);

      // R2 with manual node flag
      cur_req = "R2";
      pwm = 0; cyc(4);
      sw_below = 1; cyc(6);
      #0.5 check("R2 low side after node flag", hs_en, ls_en, 0, 1);
      sw_below = 0;

      // R9: reset in mid operation
      cur_req = "R9";
      plant_on = 1; pwm = 1; cyc(12);
      rst_n = 0;
      #0.5 check("R9 mid reset", hs_en, ls_en, 0, 0);
      cyc(3);
      rst_n = 1; cyc(14);
      pwm = 0; cyc(10);
      summary();
   end
endmodule